// File: doc/BRIEF.md
# Segment Display Timing Strobe Generator

This block produces the single timing pulse from which a segment display controller derives every frame and segment step. It counts ticks from one of two sources: the system clock, where every cycle is a tick, or a slow external oscillator. The oscillator input is brought through a synchronizer, and each of its rising edges is one tick. A coarse prescaler divides the tick stream by one of eight irregular ratios. A fine divider then divides the result again by a value from 1 to 8. Together they set the display refresh rate in two stages.

Everything runs on the system clock. The output is a one-cycle pulse on that clock, not a derived clock. Rate fields may be rewritten at any time. They are applied only at a strobe boundary, so no period is ever cut short or stretched. The source choice is applied only while the block is disabled.

Top module: `lcd_timing_strobe_gen`

## Requirements
- R1: After reset is released, `strobe` is low until the block is enabled and a full period has elapsed.
- R2: While `enable` is low, `strobe` stays low and both counters are held at zero. After `enable` rises, the first `strobe` is raised by exactly the (tap × (div+1))-th tick, counting the tick on the first enabled clock edge as tick 1.
- R3: The tap code on `ps_sel` selects a coarse ratio. The codes are 0→16, 1→64, 2→128, 3→256, 4→512, 5→1024, 6→2048 and 7→4096.
- R4: The field `div_sel` divides the coarse rate again by `div_sel`+1, giving 1 to 8.
- R5: Each `strobe` pulse lasts exactly one clock cycle.
- R6: While the block stays enabled and its settings are unchanged, strobes repeat every tap × (div+1) ticks.
- R7: With the active source 0, every clock cycle is a tick. With the active source 1, each rising edge of `ext_osc`, seen after a two-flop synchronizer, is one tick.
- R8: A change on `src_sel` while `enable` is high has no effect until `enable` is low at a clock edge.
- R9: A change on `ps_sel` or `div_sel` while enabled is applied on the clock edge that raises the next `strobe`. The period then running completes with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run (1) or hold counters at zero (0) |
| src_sel | input | 1 | Tick source: 0 = system clock, 1 = external oscillator |
| ext_osc | input | 1 | Slow external oscillator, asynchronous |
| ps_sel | input | 3 | Coarse tap code |
| div_sel | input | 3 | Fine divide field; divides by value+1 |
| strobe | output | 1 | One-cycle timing pulse |

## Verification
The checks assume that `enable`, `src_sel`, `ps_sel` and `div_sel` change synchronously to `clk`. The bench drives all of them only at falling edges. They also assume that `ext_osc` holds each level for at least two clock cycles, so that no edge is lost in the synchronizer. The bench's oscillator model toggles every three cycles, aligned to falling clock edges, which gives an exact six-cycle tick spacing. The source select is also flipped while the block runs with the oscillator frozen, so any wrongly honoured change would stop the strobes.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  localparam int SEL_W    = 3;
  localparam int DIV_W    = 3;
  localparam int NUM_TAPS = 1 << SEL_W;

  // log2 of the coarse ratio for a tap code: 16, then 64..4096
  function automatic int tap_shift(input int code);
    return (code == 0) ? 4 : code + 5;
  endfunction

  typedef struct packed {
    logic [SEL_W-1:0] tap;
    logic [DIV_W-1:0] div;
  } rate_cfg_t;

endpackage

// File: rtl/lcdt_tick_src.sv
module lcdt_tick_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic src_sel,
  input  logic ext_osc,
  output logic src_act,
  output logic tick
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  // synchronizer chain for the asynchronous oscillator
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= ext_osc;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= 1'b0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[SYNC_STAGES-1];
  end

  // source choice captured only while the block is idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       src_act <= 1'b0;
    else if (!enable) src_act <= src_sel;
  end

  logic ext_rise;
  assign ext_rise = sync_q[SYNC_STAGES-1] & ~last_q;
  assign tick     = src_act ? ext_rise : 1'b1;

endmodule

// File: rtl/lcdt_rate_cfg.sv
module lcdt_rate_cfg
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             fine_wrap,
  input  logic [SEL_W-1:0] ps_sel,
  input  logic [DIV_W-1:0] div_sel,
  output logic [SEL_W-1:0] ps_act,
  output logic [DIV_W-1:0] div_act
);

  rate_cfg_t cfg_q;

  // new rates are taken while idle or exactly at a period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (!enable || fine_wrap) begin
      cfg_q.tap <= ps_sel;
      cfg_q.div <= div_sel;
    end
  end

  assign ps_act  = cfg_q.tap;
  assign div_act = cfg_q.div;

endmodule

// File: rtl/lcdt_prescaler.sv
module lcdt_prescaler
  import lcdt_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic [SEL_W-1:0] ps_act,
  output logic [PRE_W-1:0] pre_cnt,
  output logic             tap_evt
);

  logic [PRE_W-1:0] mask_tab [NUM_TAPS];

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_mask
    assign mask_tab[g] = PRE_W'((64'd1 << tap_shift(g)) - 64'd1);
  end

  logic [PRE_W-1:0] mask;
  assign mask    = mask_tab[ps_act];
  assign tap_evt = enable && tick && ((pre_cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_cnt <= '0;
    else if (!enable) pre_cnt <= '0;
    else if (tap_evt) pre_cnt <= '0;
    else if (tick)    pre_cnt <= pre_cnt + PRE_W'(1);
  end

endmodule

// File: rtl/lcdt_fine_div.sv
module lcdt_fine_div
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tap_evt,
  input  logic [DIV_W-1:0] div_act,
  output logic             fine_wrap,
  output logic             strobe
);

  logic [DIV_W-1:0] dcnt;

  assign fine_wrap = tap_evt && (dcnt == div_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dcnt <= '0;
    else if (!enable)   dcnt <= '0;
    else if (fine_wrap) dcnt <= '0;
    else if (tap_evt)   dcnt <= dcnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= 1'b0;
    else        strobe <= fine_wrap;
  end

endmodule

// File: rtl/lcd_timing_strobe_gen.sv
module lcd_timing_strobe_gen
  import lcdt_pkg::*;
#(
  parameter int PRE_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             src_sel,
  input  logic             ext_osc,
  input  logic [SEL_W-1:0] ps_sel,
  input  logic [DIV_W-1:0] div_sel,
  output logic             strobe
);

  logic             tick;
  logic             src_act;
  logic [SEL_W-1:0] ps_act;
  logic [DIV_W-1:0] div_act;
  logic [PRE_W-1:0] pre_cnt;
  logic             tap_evt;
  logic             fine_wrap;

  lcdt_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .src_sel (src_sel),
    .ext_osc (ext_osc),
    .src_act (src_act),
    .tick    (tick)
  );

  lcdt_rate_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .fine_wrap (fine_wrap),
    .ps_sel    (ps_sel),
    .div_sel   (div_sel),
    .ps_act    (ps_act),
    .div_act   (div_act)
  );

  lcdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .tick    (tick),
    .ps_act  (ps_act),
    .pre_cnt (pre_cnt),
    .tap_evt (tap_evt)
  );

  lcdt_fine_div u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tap_evt   (tap_evt),
    .div_act   (div_act),
    .fine_wrap (fine_wrap),
    .strobe    (strobe)
  );

endmodule

// File: rtl/lcd_timing_strobe_chk.sv
module lcd_timing_strobe_chk
  import lcdt_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             strobe,
  input logic             src_act,
  input logic [SEL_W-1:0] ps_act,
  input logic [DIV_W-1:0] div_act,
  input logic             fine_wrap,
  input logic [PRE_W-1:0] pre_cnt
);

  logic [PRE_W:0] tap_lim;
  assign tap_lim = (PRE_W+1)'(64'd1 << tap_shift(int'(ps_act)));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !strobe);

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, pre_cnt} < tap_lim));

  assert_src_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable) |-> $stable(src_act));

  assert_rate_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !$past(fine_wrap)) |-> ($stable(ps_act) && $stable(div_act)));

endmodule

bind lcd_timing_strobe_gen lcd_timing_strobe_chk #(.PRE_W(PRE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .strobe    (strobe),
  .src_act   (src_act),
  .ps_act    (ps_act),
  .div_act   (div_act),
  .fine_wrap (fine_wrap),
  .pre_cnt   (pre_cnt)
);

// File: tb/lcd_timing_strobe_gen_tb.sv
module lcd_timing_strobe_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       src_sel = 1'b0;
  logic       ext_osc = 1'b0;
  logic [2:0] ps_sel = 3'd0;
  logic [2:0] div_sel = 3'd0;
  logic       strobe;

  int  vectors = 0;
  int  misses  = 0;
  bit  ext_run = 1'b0;
  bit  done    = 1'b0;

  always #5 clk = ~clk;

  lcd_timing_strobe_gen u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .src_sel (src_sel),
    .ext_osc (ext_osc),
    .ps_sel  (ps_sel),
    .div_sel (div_sel),
    .strobe  (strobe)
  );

  // external oscillator model: a level change every 3 cycles
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        ph++;
        if (ph == 3) begin
          ext_osc = ~ext_osc;
          ph = 0;
        end
      end
    end
  end

  function automatic int tap_val(input int code);
    return (code == 0) ? 16 : (1 << (code + 5));
  endfunction

  function automatic int period(input int code, input int dv);
    return tap_val(code) * (dv + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycles from enabling until the first strobe is seen
  task automatic first_strobe(input int code, input int dv, output int n);
    @(negedge clk);
    enable  = 1'b0;
    ps_sel  = 3'(code);
    div_sel = 3'(dv);
    @(negedge clk);
    enable = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!strobe && n < 40000);
  endtask

  // called at a cycle where strobe is high; counts to the next one
  task automatic next_strobe(output int n);
    @(negedge clk);
    n = 1;
    chk("R5 pulse width", int'(strobe), 0);
    while (!strobe && n < 40000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    int highs;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    highs = 0;
    repeat (40) begin
      @(negedge clk);
      highs += int'(strobe);
    end
    chk("R1 idle after reset", highs, 0);

    // R2: held while disabled even with fields moving
    highs = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      ps_sel  = 3'(i);
      div_sel = 3'(i >> 3);
      highs += int'(strobe);
    end
    chk("R2 quiet while disabled", highs, 0);

    // R2 R3 R4: first period for every combination that fits the run budget
    for (int c = 0; c < 8; c++) begin
      for (int d = 0; d < 8; d++) begin
        if (period(c, d) <= 8192) begin
          first_strobe(c, d, n);
          chk($sformatf("R2 R3 R4 first period tap%0d div%0d", c, d), n, period(c, d));
        end
      end
    end

    // R6: random settings, several periods each
    for (int k = 0; k < 10; k++) begin
      int c;
      int d;
      do begin
        c = int'($urandom_range(0, 7));
        d = int'($urandom_range(0, 7));
      end while (period(c, d) > 1024);
      first_strobe(c, d, n);
      chk("R2 first period random", n, period(c, d));
      repeat (2) begin
        next_strobe(n);
        chk($sformatf("R6 steady period tap%0d div%0d", c, d), n, period(c, d));
      end
    end

    // R9: change during a period applies at the following boundary
    first_strobe(0, 0, n);
    chk("R9 setup", n, 16);
    ps_sel = 3'd1;
    next_strobe(n);
    chk("R9 old tap completes", n, 16);
    div_sel = 3'd2;
    next_strobe(n);
    chk("R9 new tap applied", n, 64);
    next_strobe(n);
    chk("R9 new divide applied", n, 192);

    // R8: source flip while running is ignored (oscillator frozen)
    first_strobe(0, 1, n);
    chk("R8 setup", n, 32);
    src_sel = 1'b1;
    next_strobe(n);
    chk("R8 source change ignored", n, 32);
    next_strobe(n);
    chk("R8 source change ignored again", n, 32);

    // R7: external source, a tick every 6 cycles
    @(negedge clk);
    enable  = 1'b0;
    ps_sel  = 3'd0;
    div_sel = 3'd0;
    ext_run = 1'b1;
    repeat (8) @(negedge clk);
    enable = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!strobe && n < 40000);
    chk("R7 external first strobe seen", int'(strobe), 1);
    next_strobe(n);
    chk("R7 external period tap0 div0", n, 96);
    div_sel = 3'd1;
    next_strobe(n);
    chk("R7 R9 external old divide", n, 96);
    next_strobe(n);
    chk("R7 R9 external new divide", n, 192);

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      misses++;
      vectors++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule